// File: doc/BRIEF.md
# Filtered Edge Qualifier

This block prepares an asynchronous external signal, either a count clock or a start trigger, for use inside a timer clocked by a sampling clock. It first picks one of several external lines through a source selector. The chosen line passes through a two-flop synchronizer and then through a stability filter, which accepts a new level only after that level has held for a programmable number of samples. A registered edge detector then produces a one-cycle pulse for each accepted change in the direction or directions selected.

A timer uses one instance for its external count input and another for its trigger input. Each instance has its own filter and edge settings. For the count path the source count is set to one. The pulse output feeds the counting or start logic, which lies outside this block.

Top module: `edge_qualifier`

## Requirements
- R1: While rst_ni is low, pulse_o is 0 and the filtered level is cleared to 0. With all raw lines held low after reset, no pulse is produced.
- R2: The input passes two synchronizer flops before filtering. A change on the selected line, driven just after a falling clock edge and then held, shows on pulse_o after the (N+3)th rising edge. N is 1, 2, 4 or 8 for filter codes 0, 1, 2 and 3.
- R3: Filter code 0 accepts every synchronized level change. A high pulse lasting a single sampling period on the selected line is accepted.
- R4: Filter codes 1, 2 and 3 accept a new level only after 2, 4 or 8 consecutive samples at that level. A shorter excursion is dropped. Any return to the old level restarts the count.
- R5: Edge code 0 gives a pulse only for accepted low-to-high changes.
- R6: Edge code 1 gives a pulse only for accepted high-to-low changes.
- R7: Edge code 2 gives a pulse for accepted changes in both directions.
- R8: Edge code 3 gives no pulses at all.
- R9: src_sel_i chooses raw_i[src_sel_i] as the input. Activity on the other lines has no effect on pulse_o.
- R10: Each accepted change produces exactly one cycle of pulse_o high. Two pulses can fall in consecutive cycles only when edge code 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | NUM_SRC | Asynchronous external lines |
| src_sel_i | input | SEL_W | Index of the line to qualify |
| flt_code_i | input | 2 | Stability filter code (0: none, 1: 2, 2: 4, 3: 8 samples) |
| edge_code_i | input | 2 | Edge select (0 rise, 1 fall, 2 both, 3 none) |
| pulse_o | output | 1 | One-cycle qualified-edge pulse |

## Verification
The hardest case to reach from the ports is an excursion that stops just short of the stable count, or that breaks off and then resumes. A filter that loses its restart or is off by one sample behaves correctly on long pulses. The stimulus therefore drives pulses whose lengths lie on both sides of every threshold. It also adds a directed break-and-resume pattern and measures the exact latency for each filter code. Random toggling on the unselected lines runs alongside, to catch selector leakage.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int CODE_W  = 2;
  localparam int MAX_LOG = (1 << CODE_W) - 1;
  localparam int CNT_W   = MAX_LOG;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  // required consecutive differing samples minus one: 0,1,3,7
  function automatic logic [CNT_W-1:0] stable_limit(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] sh;
    sh = CODE_W'(MAX_LOG) - code;
    return {CNT_W{1'b1}} >> sh;
  endfunction
endpackage

// File: rtl/eq_sync.sv
module eq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/eq_filter.sv
module eq_filter
  import eq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              lvl_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = stable_limit(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= limit) begin
      lvl_q <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/eq_edge.sv
module eq_edge
  import eq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic [CODE_W-1:0] sel_i,
  output logic              pulse_o
);
  logic prev_q, pulse_q, rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      pulse_q <= hit;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/edge_qualifier.sv
module edge_qualifier
  import eq_pkg::*;
#(
  parameter int  NUM_SRC     = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [CODE_W-1:0]  flt_code_i,
  input  logic [CODE_W-1:0]  edge_code_i,
  output logic               pulse_o
);
  logic raw_sel, sync_lvl, flt_lvl;

  always_comb begin
    raw_sel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_sel_i == SEL_W'(i)) raw_sel = raw_i[i];
  end

  eq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_sel), .q_o(sync_lvl)
  );

  eq_filter u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_lvl), .code_i(flt_code_i), .lvl_o(flt_lvl)
  );

  eq_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(flt_lvl), .sel_i(edge_code_i), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/edge_qualifier_chk.sv
module edge_qualifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] flt_code_i,
  input logic [1:0] edge_code_i,
  input logic       pulse_o,
  input logic       sync_lvl,
  input logic       flt_lvl
);
  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !pulse_o);

  a_r3_code0_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flt_code_i) == 2'd0) |-> (flt_lvl == $past(sync_lvl)));

  a_r4_change_needs_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_lvl != $past(flt_lvl)) |-> ($past(sync_lvl) != $past(flt_lvl)));

  a_r4_change_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flt_lvl != $past(flt_lvl)) && ($past(flt_code_i) != 2'd0))
      |-> ($past(sync_lvl, 2) == $past(sync_lvl)));

  a_r5_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && $past(edge_code_i) == 2'd0) |-> ($past(flt_lvl) && !$past(flt_lvl, 2)));

  a_r6_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && $past(edge_code_i) == 2'd1) |-> (!$past(flt_lvl) && $past(flt_lvl, 2)));

  a_r8_none_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(edge_code_i) == 2'd3) |-> !pulse_o);

  a_r10_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && $past(pulse_o)) |-> ($past(edge_code_i) == 2'd2));
endmodule

bind edge_qualifier edge_qualifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flt_code_i(flt_code_i), .edge_code_i(edge_code_i),
  .pulse_o(pulse_o), .sync_lvl(sync_lvl), .flt_lvl(flt_lvl)
);

// File: tb/edge_qualifier_test.sv
module edge_qualifier_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] raw_i = '0;
  logic [2:0] src_sel_i = '0;
  logic [1:0] flt_code_i = '0;
  logic [1:0] edge_code_i = '0;
  logic       pulse_o;

  int n_run = 0, n_fail = 0, hits = 0, run_len = 0, max_run = 0, cyc_cnt = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  edge_qualifier uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i), .src_sel_i(src_sel_i),
    .flt_code_i(flt_code_i), .edge_code_i(edge_code_i), .pulse_o(pulse_o)
  );

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    if (pulse_o) begin hits++; run_len++; if (run_len > max_run) max_run = run_len; end
    else run_len = 0;
  endtask

  function automatic int exp_pulses(int code, int edg, int len);
    bit acc = len >= (1 << code);
    int n = 0;
    if (acc && (edg == 0 || edg == 2)) n++;
    if (acc && (edg == 1 || edg == 2)) n++;
    return n;
  endfunction

  function automatic logic [7:0] noise(int sel, bit v, bit en);
    logic [7:0] r = en ? 8'($urandom) : 8'h0;
    r[sel] = v;
    return r;
  endfunction

  task automatic idle(int n);
    raw_i = '0;
    repeat (n) cyc();
  endtask

  task automatic run_pulse(int code, int edg, int sel, int len, bit nz, string tag);
    flt_code_i = 2'(code); edge_code_i = 2'(edg); src_sel_i = 3'(sel);
    idle(24);
    hits = 0; max_run = 0; run_len = 0;
    for (int i = 0; i < len; i++) begin raw_i = noise(sel, 1'b1, nz); cyc(); end
    for (int i = 0; i < 30; i++) begin raw_i = noise(sel, 1'b0, nz); cyc(); end
    check(hits == exp_pulses(code, edg, len), tag, hits, exp_pulses(code, edg, len));
    if (edg != 2) check(max_run <= 1, "R10 pulse width", max_run, 1);
  endtask

  task automatic latency(int code);
    int got = 0;
    flt_code_i = 2'(code); edge_code_i = 2'd0; src_sel_i = 3'd0;
    idle(24);
    raw_i = 8'h01;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      if (pulse_o && got == 0) got = k;
    end
    check(got == (1 << code) + 3, "R2 latency", got, (1 << code) + 3);
    idle(30);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset holds output low even with input activity
    for (int i = 0; i < 6; i++) begin
      raw_i = 8'($urandom); @(negedge clk_i);
      check(pulse_o == 1'b0, "R1 during reset", int'(pulse_o), 0);
    end
    raw_i = '0;
    @(negedge clk_i); rst_ni = 1'b1;
    hits = 0; idle(30);
    check(hits == 0, "R1 idle after reset", hits, 0);

    for (int c = 0; c < 4; c++) latency(c);

    run_pulse(0, 0, 0, 1, 0, "R3 one-sample pulse accepted");
    run_pulse(1, 2, 0, 1, 0, "R4 code1 short dropped");
    run_pulse(1, 2, 0, 2, 0, "R4 code1 exact accepted");
    run_pulse(2, 2, 0, 3, 0, "R4 code2 short dropped");
    run_pulse(2, 2, 0, 4, 0, "R4 code2 exact accepted");
    run_pulse(3, 2, 0, 7, 0, "R4 code3 short dropped");
    run_pulse(3, 2, 0, 8, 0, "R4 code3 exact accepted");
    run_pulse(1, 0, 2, 5, 0, "R5 rise only");
    run_pulse(1, 1, 2, 5, 0, "R6 fall only");
    run_pulse(0, 2, 2, 5, 0, "R7 both edges");
    run_pulse(0, 3, 2, 5, 0, "R8 code3 silent");
    run_pulse(0, 0, 0, 1, 0, "R10 single cycle");

    // R4: break then resume restarts the count (code 2 needs 4)
    flt_code_i = 2'd2; edge_code_i = 2'd2; src_sel_i = 3'd1;
    idle(24); hits = 0;
    raw_i = 8'h02; repeat (3) cyc();
    raw_i = 8'h00; cyc();
    raw_i = 8'h02; repeat (3) cyc();
    idle(30);
    check(hits == 0, "R4 restart on break", hits, 0);

    // R9: unselected lines ignored
    flt_code_i = 2'd0; edge_code_i = 2'd2; src_sel_i = 3'd3;
    idle(24); hits = 0;
    for (int i = 0; i < 40; i++) begin raw_i = noise(3, 1'b0, 1'b1); cyc(); end
    idle(10);
    check(hits == 0, "R9 other lines ignored", hits, 0);

    for (int t = 0; t < 120; t++) begin
      int c = $urandom_range(0, 3);
      int e = $urandom_range(0, 3);
      int s = $urandom_range(0, 7);
      int l = $urandom_range(1, 12);
      run_pulse(c, e, s, l, 1'b1, "R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule